// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes written by a host into asynchronous NRZ frames on a single output line. The host writes a character, plus an optional ninth bit, into a holding buffer. Whenever the shifter reaches a frame boundary with nothing to send, the buffered character moves into the shifter. The next character can therefore be written while the current one is still on the line. Each frame has a low start bit, 8 or 9 data bits sent least significant bit first, and a high stop bit.

Time advances only on an external bit-rate tick; a bit period is the span between two ticks. When transmission is enabled, the block first sends one all-ones frame. Clearing the enable lets any frame in progress finish before the line rests high. While a break is requested, the block sends frames of all zeros, and it follows the last of them with at least one high stop bit.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, txd is 1, buf_empty is 1 and tx_done is 1.
- R2: With nine_bit_mode = 0, a character frame lasts 10 bit periods: start bit 0, wr_data[0] through wr_data[7] in that order, then stop bit 1.
- R3: With nine_bit_mode = 1, a frame lasts 11 bit periods. The bit captured from wr_bit8 at the write is sent after data bit 7 and before the stop bit.
- R4: txd changes only on the clock edge that samples bit_tick high.
- R5: buf_empty rises only on a tick edge, when the buffered character enters the shifter. A character written while the previous one is shifting starts on the bit period right after the previous stop bit, with no idle gap.
- R6: A write while the buffer is full replaces the pending character and does not alter the frame on the line.
- R7: buf_empty is 0 in the cycle after any write strobe. This holds even when the write falls on the same edge that moves the older character into the shifter; that older character is still sent, followed by the new one.
- R8: tx_done is 1 only while the buffer is empty, no frame (character, idle, break or stop) is in progress, and txd is 1.
- R9: On a rise of tx_en, the line sends one all-ones frame of 10 or 11 bit periods before the first start bit.
- R10: Clearing tx_en mid-frame lets that frame finish. Afterwards txd stays 1 and any pending character stays buffered until tx_en returns.
- R11: While brk_req is held with tx_en set, txd is 0 for a whole number of frames (a multiple of 10 bit periods in 8-bit mode). After release, exactly one high bit precedes an already pending character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit period |
| tx_en | input | 1 | Transmit enable |
| nine_bit_mode | input | 1 | 0: 8 data bits, 1: 9 data bits |
| brk_req | input | 1 | Send break frames while high |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to buffer |
| wr_bit8 | input | 1 | Ninth data bit, captured with wr_stb |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding buffer is free |
| tx_done | output | 1 | Buffer and shifter both idle |

## Verification
A host write and the transfer of the buffer into the shifter can land on the same clock edge. The bench provokes this by timing its strobe to the cycle in which it drives the bit tick at a frame boundary, with an older character already waiting. It then requires buf_empty to stay low after that edge. It also decodes the older character from the line, followed at once by the newer one, so that neither is lost or duplicated.

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              nine_bit_mode,
  input  logic              brk_req,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit8,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done
);
  localparam int SH_W = DATA_W + 3;
  localparam int CW   = $clog2(SH_W + 1);
  localparam int LEN_S = DATA_W + 2;
  localparam int LEN_L = DATA_W + 3;

  typedef enum logic [2:0] {NX_IDLE, NX_PRE, NX_BRK, NX_STOP, NX_CHAR} nxt_e;

  logic [DATA_W:0]   buf_q;
  logic              buf_full;
  logic [SH_W-1:0]   sh_q;
  logic [CW-1:0]     cnt_q;
  logic              brk_tail;
  logic              en_arm;
  nxt_e              nxt;

  wire          busy     = (cnt_q != '0);
  wire [CW-1:0] flen     = nine_bit_mode ? CW'(LEN_L) : CW'(LEN_S);
  wire          boundary = bit_tick && (cnt_q <= CW'(1));
  wire          load_chr = boundary && (nxt == NX_CHAR);

  always_comb begin
    if (!tx_en)        nxt = NX_IDLE;
    else if (en_arm)   nxt = NX_PRE;
    else if (brk_req)  nxt = NX_BRK;
    else if (brk_tail) nxt = NX_STOP;
    else if (buf_full) nxt = NX_CHAR;
    else               nxt = NX_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
    end else if (wr_stb) begin
      buf_q    <= {wr_bit8, wr_data};
      buf_full <= 1'b1;
    end else if (load_chr) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q     <= '1;
      cnt_q    <= '0;
      brk_tail <= 1'b0;
      en_arm   <= 1'b1;
    end else begin
      if (!tx_en) en_arm <= 1'b1;
      else if (boundary && nxt == NX_PRE) en_arm <= 1'b0;
      if (bit_tick) begin
        if (cnt_q > CW'(1)) begin
          sh_q  <= {1'b1, sh_q[SH_W-1:1]};
          cnt_q <= cnt_q - CW'(1);
        end else begin
          unique case (nxt)
            NX_IDLE: begin sh_q <= '1; cnt_q <= '0;    brk_tail <= 1'b0; end
            NX_PRE:  begin sh_q <= '1; cnt_q <= flen;  brk_tail <= 1'b0; end
            NX_BRK:  begin sh_q <= '0; cnt_q <= flen;  brk_tail <= 1'b1; end
            NX_STOP: begin sh_q <= '1; cnt_q <= CW'(1); brk_tail <= 1'b0; end
            NX_CHAR: begin
              sh_q  <= nine_bit_mode ? {1'b1, buf_q, 1'b0}
                                     : {2'b11, buf_q[DATA_W-1:0], 1'b0};
              cnt_q <= flen;
            end
            default: begin sh_q <= '1; cnt_q <= '0; end
          endcase
        end
      end
    end
  end

  assign txd       = sh_q[0];
  assign buf_empty = ~buf_full;
  assign tx_done   = ~buf_full & ~busy;

  AST_LINE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd)); // R4
  AST_EMPTY_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(bit_tick)); // R5
  AST_WRITE_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !buf_empty); // R7
  AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (buf_empty && txd)); // R8
  AST_NO_FRAME_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R10
endmodule

// File: tb/uart_dbuf_tx_tb_top.sv
module uart_dbuf_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic tx_en = 1'b0;
  logic nine_bit_mode = 1'b0;
  logic brk_req = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_bit8 = 1'b0;
  logic txd, buf_empty, tx_done;

  int n_chk = 0;
  int n_fail = 0;
  int nlog = 0;
  int r4_bad = 0;
  logic line_log [0:4095];
  logic [1:0] ph = '0;
  logic last_txd = 1'b1;

  always #5 clk = ~clk;

  uart_dbuf_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .nine_bit_mode(nine_bit_mode), .brk_req(brk_req), .wr_stb(wr_stb),
    .wr_data(wr_data), .wr_bit8(wr_bit8), .txd(txd),
    .buf_empty(buf_empty), .tx_done(tx_done)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (txd !== last_txd && !bit_tick) r4_bad++;
      last_txd = txd;
      if (ph == 2'd1 && nlog < 4096) begin
        line_log[nlog] = txd;
        nlog++;
      end
    end
    bit_tick <= (ph == 2'd3);
    ph <= ph + 2'd1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic periods(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic write_buf(input logic [7:0] d, input logic b8);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = d; wr_bit8 = b8;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_empty();
    while (buf_empty !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_done();
    while (tx_done !== 1'b1) @(negedge clk);
  endtask

  function automatic int find_start(input int from);
    for (int i = from; i < nlog; i++) if (line_log[i] === 1'b0) return i;
    return -1;
  endfunction

  function automatic int data_at(input int p, input int nb);
    int v = 0;
    for (int i = 0; i < nb; i++) if (line_log[p + 1 + i] === 1'b1) v |= (1 << i);
    return v;
  endfunction

  task automatic check_frame(input string req, input int p, input int exp, input int nb);
    chk(req, "start bit found", (p >= 0) ? 1 : 0, 1);
    if (p >= 0) begin
      chk(req, "data bits", data_at(p, nb), exp);
      chk(req, "stop bit", int'(line_log[p + nb + 1]), 1);
    end
  endtask

  task automatic t_reset();
    chk("R1", "txd after reset", int'(txd), 1);
    chk("R1", "buf_empty after reset", int'(buf_empty), 1);
    chk("R1", "tx_done after reset", int'(tx_done), 1);
  endtask

  task automatic t_first_char();
    int mark, p;
    mark = nlog;
    @(negedge clk); tx_en = 1'b1;
    write_buf(8'hA5, 1'b0);
    chk("R7", "buf_empty after write", int'(buf_empty), 0);
    wait_empty();
    chk("R5", "start bit at transfer", int'(txd), 0);
    chk("R8", "tx_done while shifting", int'(tx_done), 0);
    periods(12);
    p = find_start(mark);
    chk("R9", "idle frame length ok", (p - mark >= 10 && p - mark <= 12) ? 1 : 0, 1);
    check_frame("R2", p, 32'hA5, 8);
    wait_done();
    chk("R8", "tx_done after frame", int'(tx_done), 1);
  endtask

  task automatic t_back_to_back();
    int mark, p;
    mark = nlog;
    write_buf(8'h3C, 1'b0);
    wait_empty();
    write_buf(8'hC3, 1'b0);
    wait_done();
    periods(2);
    p = find_start(mark);
    check_frame("R2", p, 32'h3C, 8);
    chk("R5", "second start right after stop", int'(line_log[p + 10]), 0);
    check_frame("R5", p + 10, 32'hC3, 8);
  endtask

  task automatic t_overwrite();
    int mark, p;
    mark = nlog;
    write_buf(8'h11, 1'b0);
    wait_empty();
    periods(2);
    write_buf(8'h22, 1'b0);
    periods(1);
    write_buf(8'h33, 1'b0);
    wait_done();
    periods(3);
    p = find_start(mark);
    check_frame("R6", p, 32'h11, 8);
    check_frame("R6", p + 10, 32'h33, 8);
    chk("R6", "no third frame", find_start(p + 20), -1);
  endtask

  task automatic t_nine_bit();
    int mark, p;
    nine_bit_mode = 1'b1;
    mark = nlog;
    write_buf(8'h5A, 1'b1);
    wait_empty();
    write_buf(8'h0F, 1'b0);
    wait_done();
    periods(2);
    p = find_start(mark);
    check_frame("R3", p, 32'h15A, 9);
    check_frame("R3", p + 11, 32'h00F, 9);
    nine_bit_mode = 1'b0;
  endtask

  task automatic t_collision();
    int mark, p;
    mark = nlog;
    @(negedge clk);
    while (ph != 2'd0) @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'h96; wr_bit8 = 1'b0;
    @(negedge clk);
    wr_stb = 1'b0;
    while (ph != 2'd3) @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'h6B;
    @(negedge clk);
    wr_stb = 1'b0;
    chk("R7", "buf_empty after same-edge write", int'(buf_empty), 0);
    chk("R7", "older char started", int'(txd), 0);
    wait_done();
    periods(2);
    p = find_start(mark);
    check_frame("R7", p, 32'h96, 8);
    check_frame("R7", p + 10, 32'h6B, 8);
  endtask

  task automatic t_disable();
    int mark, p, ones;
    mark = nlog;
    write_buf(8'h81, 1'b0);
    wait_empty();
    write_buf(8'h42, 1'b0);
    periods(3);
    @(negedge clk); tx_en = 1'b0;
    periods(30);
    chk("R10", "pending kept", int'(buf_empty), 0);
    chk("R10", "tx_done low with pending", int'(tx_done), 0);
    p = find_start(mark);
    check_frame("R10", p, 32'h81, 8);
    ones = 1;
    for (int i = p + 10; i < nlog; i++) if (line_log[i] !== 1'b1) ones = 0;
    chk("R10", "line high while disabled", ones, 1);
    mark = nlog;
    @(negedge clk); tx_en = 1'b1;
    wait_done();
    periods(2);
    p = find_start(mark);
    chk("R9", "idle frame on re-enable", (p - mark >= 10 && p - mark <= 12) ? 1 : 0, 1);
    check_frame("R9", p, 32'h42, 8);
  endtask

  task automatic t_break();
    int mark, p, z;
    mark = nlog;
    @(negedge clk); brk_req = 1'b1;
    periods(12);
    write_buf(8'h99, 1'b0);
    periods(12);
    chk("R11", "tx_done during break", int'(tx_done), 0);
    @(negedge clk); brk_req = 1'b0;
    wait_done();
    periods(2);
    p = find_start(mark);
    z = 0;
    while (p >= 0 && p + z < nlog && line_log[p + z] === 1'b0) z++;
    chk("R11", "break whole frames", z % 10, 0);
    chk("R11", "break at least two frames", (z >= 20) ? 1 : 0, 1);
    chk("R11", "single stop after break", int'(line_log[p + z]), 1);
    chk("R11", "start right after stop", int'(line_log[p + z + 1]), 0);
    check_frame("R11", p + z + 1, 32'h99, 8);
  endtask

  task automatic run_all();
    t_reset();
    t_first_char();
    t_back_to_back();
    t_overwrite();
    t_nine_bit();
    t_collision();
    t_disable();
    t_break();
    chk("R4", "line moved only on tick edges", r4_bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule